// File: doc/BRIEF.md
# Two-Winding Stepper Sequence Generator

This block sequences a bipolar stepper motor that has two windings. Each of its two outputs pairs a polarity bit with a 2-bit current-grade code, and each pair feeds one bridge current controller. A rising edge on the step input moves an internal position index one place forward or back. The index then selects the polarity and current grade of each winding.

Two stepping modes are available. Half-step mode uses eight positions with constant-torque weighting. Quarter-step mode uses sixteen positions and approximates a sine and cosine pair with four current grades. Three further controls shape the drive:

- A hold input caps the current while the rotor is parked.
- A programmable blanking count switches both bridges off for a few cycles after each step, so the winding current decays quickly.
- An enable input switches everything off and freezes the position.

Top module: `stepseq_top`

## Requirements
- R1: While reset is asserted both level outputs are 2'b11 and both polarity outputs are 0. The index resets to position 0, and the first output after reset shows that position.
- R2: Only a 0-to-1 transition of `stepPulse` (sampled on the clock) moves the index. Holding the input high for many cycles moves it exactly once.
- R3: A step with `dirFwd`=1 adds one to the index and a step with `dirFwd`=0 subtracts one. In quarter mode the index wraps modulo 16, and in half mode modulo 8.
- R4: In quarter mode position p (0..15) stands for the electrical angle p*22.5 degrees. Winding 1 follows the cosine of that angle and winding 2 the sine. Each magnitude takes the nearest grade from full, 67%, 41% and off, so within a quadrant the winding 1/winding 2 grades run full/off, full/41, 67/67, 41/full.
- R5: In half mode position h maps to angle h*45 degrees. A winding that is energized alone gets the full grade, and when both are energized each gets 67%. The 41% grade never appears unless hold is active.
- R6: Level codes are bit 0 = I0 and bit 1 = I1: full = 2'b00, 67% = 2'b01, 41% = 2'b10, off = 2'b11.
- R7: Polarity bit 1 means positive current. Winding 1 is positive in quadrants 0 and 3, and winding 2 in quadrants 0 and 1. The quadrant is bits 3:2 of the quarter position, and it also decides the polarity of a winding whose grade is off.
- R8: While `holdReq` is high, any grade other than off is output as 41% (2'b10).
- R9: With `gapCycles`=G, both level outputs are 2'b11 for G cycles after the output would first show the new position, and the new position then appears. With G=0 no gap is inserted.
- R10: While `enable` is low, both level outputs are 2'b11, step edges are ignored and the index is held. When `enable` returns, the unchanged position is shown.
- R11: Outputs are registered. A step captured at clock edge k shows its new position at edge k+1, and hold, enable and mode changes also take effect one edge after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepPulse | input | 1 | Step request; its rising edge moves the index |
| dirFwd | input | 1 | 1 = step forward, 0 = step backward |
| quarterMode | input | 1 | 1 = sixteen-position mode, 0 = eight-position mode |
| holdReq | input | 1 | Caps every non-off grade at 41% |
| enable | input | 1 | 0 = all off and position frozen |
| gapCycles | input | GAP_W | Number of all-off cycles after each step |
| w1Dir | output | 1 | Winding 1 polarity |
| w1Lvl | output | 2 | Winding 1 grade code {I1,I0} |
| w2Dir | output | 1 | Winding 2 polarity |
| w2Lvl | output | 2 | Winding 2 grade code {I1,I0} |

## Verification
A step captured at edge k changes the outputs at edge k+1, or at edge k+G+1 after G off cycles. A change on hold, enable or mode is visible one edge after it is sampled. The bench drives every input on the falling edge and samples on the next falling edge. Right after the capturing edge it confirms that the old position is still shown, then it checks each blanking cycle and finally the new position. Expected grades and polarities come from cosine and sine of the step angle, quantized to the nearest grade.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int POS_W  = 4;
  localparam int HALF_W = POS_W - 1;

  typedef enum logic [1:0] {
    LVL_FULL = 2'b00,
    LVL_MID  = 2'b01,
    LVL_LOW  = 2'b10,
    LVL_OFF  = 2'b11
  } level_e;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic quarter;
    logic drive;
  } seqStrobe_t;
endpackage

// File: rtl/stepseq_ctrl.sv
module stepseq_ctrl
  import stepseq_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepPulse,
  input  logic             dirFwd,
  input  logic             quarterMode,
  input  logic             enable,
  input  logic [GAP_W-1:0] gapCycles,
  output seqStrobe_t       strobe
);
  logic             stepPrev;
  logic [GAP_W-1:0] gapCnt;
  logic             stepEdge;
  logic             take;

  always_comb begin
    stepEdge        = stepPulse & ~stepPrev;
    take            = stepEdge & enable;
    strobe.stepUp   = take & dirFwd;
    strobe.stepDown = take & ~dirFwd;
    strobe.quarter  = quarterMode;
    strobe.drive    = enable & (gapCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      gapCnt   <= '0;
    end else begin
      stepPrev <= stepPulse;
      if (!enable)
        gapCnt <= '0;
      else if (take)
        gapCnt <= gapCycles;
      else if (gapCnt != '0)
        gapCnt <= gapCnt - 1'b1;
    end
  end

  AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !take && gapCnt != '0) |=> gapCnt == $past(gapCnt) - 1'b1); // R9
  AST_GAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    take |=> gapCnt == $past(gapCycles)); // R9
  AST_ONE_STEP_PER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp || strobe.stepDown) |=> !(strobe.stepUp || strobe.stepDown)); // R2
endmodule

// File: rtl/stepseq_datapath.sv
module stepseq_datapath
  import stepseq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic            holdReq,
  output logic [1:0][1:0] lvlOut,
  output logic [1:0]      dirOut
);
  logic [POS_W-1:0]  idx;
  logic [POS_W-1:0]  pos;
  logic [1:0]        quad;
  logic [1:0]        sub;
  logic [HALF_W-1:0] halfIdx;

  assign halfIdx = idx[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)
      idx <= '0;
    else if (strobe.stepUp)
      idx <= strobe.quarter ? idx + 1'b1 : {1'b0, halfIdx + 1'b1};
    else if (strobe.stepDown)
      idx <= strobe.quarter ? idx - 1'b1 : {1'b0, halfIdx - 1'b1};
  end

  always_comb begin
    pos  = strobe.quarter ? idx : {halfIdx, 1'b0};
    quad = pos[POS_W-1:POS_W-2];
    sub  = pos[1:0];
  end

  for (genvar w = 0; w < 2; w++) begin : g_wind
    logic   swapTbl;
    level_e rawLvl;
    level_e nextLvl;
    logic   nextDir;
    logic [1:0] lvlQ;
    logic   dirQ;

    always_comb begin
      swapTbl = quad[0] ^ (w == 1);
      if (!swapTbl) begin
        case (sub)
          2'd0:    rawLvl = LVL_FULL;
          2'd1:    rawLvl = LVL_FULL;
          2'd2:    rawLvl = LVL_MID;
          default: rawLvl = LVL_LOW;
        endcase
      end else begin
        case (sub)
          2'd0:    rawLvl = LVL_OFF;
          2'd1:    rawLvl = LVL_LOW;
          2'd2:    rawLvl = LVL_MID;
          default: rawLvl = LVL_FULL;
        endcase
      end
      if (w == 0)
        nextDir = ~(quad[1] ^ quad[0]);
      else
        nextDir = ~quad[1];
      if (!strobe.drive)
        nextLvl = LVL_OFF;
      else if (holdReq && rawLvl != LVL_OFF)
        nextLvl = LVL_LOW;
      else
        nextLvl = rawLvl;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlQ <= LVL_OFF;
        dirQ <= 1'b0;
      end else begin
        lvlQ <= nextLvl;
        dirQ <= nextDir;
      end
    end

    assign lvlOut[w] = lvlQ;
    assign dirOut[w] = dirQ;
  end

  AST_IDX_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepUp || strobe.stepDown) |=> $stable(idx)); // R10
  AST_HALF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.quarter && (strobe.stepUp || strobe.stepDown)) |=> idx[POS_W-1] == 1'b0); // R3
  AST_NOT_BOTH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drive |=> !(lvlOut[0] == LVL_OFF && lvlOut[1] == LVL_OFF)); // R4
  AST_HALF_NO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && !strobe.quarter && !holdReq) |=>
      (lvlOut[0] != LVL_LOW && lvlOut[1] != LVL_LOW)); // R5
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepPulse,
  input  logic             dirFwd,
  input  logic             quarterMode,
  input  logic             holdReq,
  input  logic             enable,
  input  logic [GAP_W-1:0] gapCycles,
  output logic             w1Dir,
  output logic [1:0]       w1Lvl,
  output logic             w2Dir,
  output logic [1:0]       w2Lvl
);
  seqStrobe_t      strobe;
  logic [1:0][1:0] lvlOut;
  logic [1:0]      dirOut;

  stepseq_ctrl #(.GAP_W(GAP_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stepPulse   (stepPulse),
    .dirFwd      (dirFwd),
    .quarterMode (quarterMode),
    .enable      (enable),
    .gapCycles   (gapCycles),
    .strobe      (strobe)
  );

  stepseq_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .holdReq (holdReq),
    .lvlOut  (lvlOut),
    .dirOut  (dirOut)
  );

  assign w1Lvl = lvlOut[0];
  assign w2Lvl = lvlOut[1];
  assign w1Dir = dirOut[0];
  assign w2Dir = dirOut[1];

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (w1Lvl == 2'b11 && w2Lvl == 2'b11)); // R10
  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> (w1Lvl[1] && w2Lvl[1])); // R8
endmodule

// File: tb/test_stepseq_top.sv
module test_stepseq_top;
  localparam int GAP_W = 8;
  localparam real PI = 3.14159265358979;

  logic             clk = 1'b0;
  logic             rstN;
  logic             stepPulse;
  logic             dirFwd;
  logic             quarterMode;
  logic             holdReq;
  logic             enable;
  logic [GAP_W-1:0] gapCycles;
  logic             w1Dir;
  logic [1:0]       w1Lvl;
  logic             w2Dir;
  logic [1:0]       w2Lvl;

  int total = 0;
  int bad = 0;
  int modelIdx = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stepseq_top #(.GAP_W(GAP_W)) i_stepseq_top (
    .clk(clk), .rstN(rstN), .stepPulse(stepPulse), .dirFwd(dirFwd),
    .quarterMode(quarterMode), .holdReq(holdReq), .enable(enable),
    .gapCycles(gapCycles), .w1Dir(w1Dir), .w1Lvl(w1Lvl),
    .w2Dir(w2Dir), .w2Lvl(w2Lvl)
  );

  function automatic logic [1:0] quant(real m);
    real a;
    a = (m < 0.0) ? -m : m;
    if (a > 0.835) return 2'b00;
    if (a > 0.54)  return 2'b01;
    if (a > 0.205) return 2'b10;
    return 2'b11;
  endfunction

  task automatic expectCheck(string tag, bit offExp);
    int  p;
    real ang;
    logic [1:0] e1, e2;
    logic d1, d2;
    p   = quarterMode ? modelIdx : 2 * modelIdx;
    ang = p * PI / 8.0;
    e1  = quant($cos(ang));
    e2  = quant($sin(ang));
    d1  = $cos(ang + 0.01) > 0.0;
    d2  = $sin(ang + 0.01) > 0.0;
    if (holdReq && e1 != 2'b11) e1 = 2'b10;
    if (holdReq && e2 != 2'b11) e2 = 2'b10;
    if (offExp) begin e1 = 2'b11; e2 = 2'b11; end
    total++;
    if (w1Lvl !== e1 || w2Lvl !== e2 || (!offExp && (w1Dir !== d1 || w2Dir !== d2))) begin
      bad++;
      $display("FAIL %s pos=%0d: got dir=%b%b lvl=%b/%b expected dir=%b%b lvl=%b/%b",
               tag, p, w1Dir, w2Dir, w1Lvl, w2Lvl, d1, d2, e1, e2);
    end
  endtask

  task automatic advanceModel();
    if (quarterMode) modelIdx = (modelIdx + (dirFwd ? 1 : 15)) % 16;
    else             modelIdx = ((modelIdx % 8) + (dirFwd ? 1 : 7)) % 8;
  endtask

  // Starts and ends at a falling edge; the step edge is captured at edge k.
  task automatic stepOnce(string tag);
    stepPulse = 1'b1;
    @(negedge clk);
    stepPulse = 1'b0;
    expectCheck("R11 old position before update", 1'b0);
    advanceModel();
    for (int g = 0; g < int'(gapCycles); g++) begin
      @(negedge clk);
      expectCheck("R9 blanking after step", 1'b1);
    end
    @(negedge clk);
    expectCheck(tag, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stepPulse = 1'b0; dirFwd = 1'b1; quarterMode = 1'b1;
    holdReq = 1'b0; enable = 1'b1; gapCycles = '0;
    repeat (3) @(negedge clk);
    total++;
    if (w1Lvl !== 2'b11 || w2Lvl !== 2'b11 || w1Dir !== 1'b0 || w2Dir !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got %b%b %b/%b expected 00 11/11", w1Dir, w2Dir, w1Lvl, w2Lvl);
    end
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectCheck("R1 first position after reset", 1'b0);

    // R4 R6 R7 R3: quarter mode forward with wrap, then backward
    for (int i = 0; i < 17; i++) stepOnce("R4 quarter forward");
    dirFwd = 1'b0;
    for (int i = 0; i < 17; i++) stepOnce("R3 quarter backward");

    // R5: half mode
    quarterMode = 1'b0;
    @(negedge clk);
    modelIdx = modelIdx % 8;
    expectCheck("R5 mode change", 1'b0);
    dirFwd = 1'b1;
    for (int i = 0; i < 9; i++) stepOnce("R5 half forward");
    dirFwd = 1'b0;
    for (int i = 0; i < 9; i++) stepOnce("R5 half backward");

    // R2: long pulse advances once
    dirFwd = 1'b1;
    stepPulse = 1'b1;
    repeat (6) @(negedge clk);
    stepPulse = 1'b0;
    advanceModel();
    @(negedge clk);
    expectCheck("R2 long pulse single step", 1'b0);

    // R8: hold caps grades, quarter sweep
    quarterMode = 1'b1;
    holdReq = 1'b1;
    @(negedge clk);
    expectCheck("R8 hold applied", 1'b0);
    for (int i = 0; i < 16; i++) stepOnce("R8 hold sweep");
    holdReq = 1'b0;
    @(negedge clk);
    expectCheck("R8 hold released", 1'b0);

    // R9: blanking gap of three cycles, then one cycle
    gapCycles = 8'd3;
    for (int i = 0; i < 4; i++) stepOnce("R9 after gap of 3");
    gapCycles = 8'd1;
    stepOnce("R9 after gap of 1");
    gapCycles = 8'd0;

    // R10: disable, steps ignored, position kept
    enable = 1'b0;
    @(negedge clk);
    expectCheck("R10 disabled off", 1'b1);
    for (int i = 0; i < 3; i++) begin
      stepPulse = 1'b1;
      @(negedge clk);
      stepPulse = 1'b0;
      @(negedge clk);
      expectCheck("R10 step ignored while disabled", 1'b1);
    end
    enable = 1'b1;
    @(negedge clk);
    expectCheck("R10 position held after enable", 1'b0);
    stepOnce("R10 stepping resumes");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule